// File: doc/BRIEF.md
# Converter System Calibration Sequencer

This block sits on the host side of a self-calibrating sampling converter and runs the converter's system calibration routine from start to finish. One start request, together with a routine select, launches either a set of separate passes or a set of combined passes. In a separate pass, an offset calibration is followed by a gain calibration. In a combined pass, a gain-plus-offset calibration is done as one step. The sequencer pulses the converter's calibration strobe and convert strobe. It tells the analog front end which level to present through two select outputs, one for the full-scale level and one for the offset level. It follows the converter's BUSY line from one step to the next.

The repeat count is fixed by the routine. Offset and gain errors interact, so separate passes run twice and combined passes run three times. Combined passes never run more than three times. Before every strobe, the chosen level is held for a setup window of at least 100 ns, counted in whole clock cycles from the clock frequency parameter. Each BUSY handshake is guarded by a timeout that software can set. When a timeout expires, the sequence stops, every output returns to idle and an error flag is raised. A normal end is marked by a one-cycle done pulse.

The polarity input is captured when a start is accepted. It is presented as the offset target indication: midscale for bipolar and zero scale for unipolar. The gain step always targets positive full scale.

Top module: `calseq_ctrl`

## Requirements
- R1: After reset, cal_stb, cnv_stb, sel_fs, sel_ofs, ofs_mid, active, done and err are all low.
- R2: With mode_comb low, the sequencer runs 2 passes. Each pass has two steps, and each step is one cal_stb pulse. The first step is taken with sel_ofs high (offset level) and the second with sel_fs high (full-scale level). That makes 4 cal_stb pulses and no cnv_stb pulse.
- R3: With mode_comb high, the sequencer runs 3 passes. Each pass first pulses cal_stb with sel_fs high, then pulses cnv_stb with sel_ofs high. That makes 3 pulses of each strobe. The two strobes are never high together, and no fourth combined pass is started.
- R4: The selected level stays unchanged for at least SETUP_CYC = ceil(SETUP_NS x CLK_KHZ / 10^6) cycles before each strobe's rising edge. That is 13 cycles for 100 ns at 125 MHz.
- R5: Each strobe pulse is high for exactly STROBE_CYC cycles (default 4).
- R6: sel_fs and sel_ofs are never high together. Neither changes, and no new strobe rises, while busy_in is high.
- R7: Each BUSY wait has a limit. If busy_in does not rise, or does not fall, within tmo_limit+1 cycles of the wait beginning, the sequence aborts. In the same cycle err rises while strobes, selects and active are low, and no done pulse is given. Before the limit expires, err stays low.
- R8: err stays high after an abort until the next accepted start, which clears it.
- R9: A start seen while active is high is ignored. The running routine keeps its mode and its pulse count.
- R10: At the end of the final pass, done is high for exactly one cycle, once per sequence. After that, active and all strobes and selects are low.
- R11: ofs_mid takes the value of bipolar (high = midscale, low = zero scale) when a start is accepted. It holds that value even if bipolar changes during the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only while idle |
| mode_comb | input | 1 | Routine select: 0 separate passes, 1 combined passes |
| bipolar | input | 1 | Converter polarity, 1 bipolar |
| tmo_limit | input | TMO_W | BUSY wait limit in cycles, minus one |
| busy_in | input | 1 | Converter BUSY line (asynchronous) |
| cal_stb | output | 1 | Calibration strobe, active high |
| cnv_stb | output | 1 | Convert strobe, active high |
| sel_fs | output | 1 | Front end: present the full-scale level |
| sel_ofs | output | 1 | Front end: present the offset level |
| ofs_mid | output | 1 | Offset target is midscale (1) or zero scale (0) |
| active | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| err | output | 1 | Sticky timeout flag |

## Verification
The bench models the converter as a BUSY responder with several rise delays and high times. For each routine it records the order of strobe and level pairs. A design that swapped the level order, or gave gain the wrong priority, would present a pair sequence that differs from the expected one. A design that counted passes wrongly would give the wrong pulse totals. A design that cut the setup window short by a cycle, or widened a strobe, would be caught by the setup and pulse-width measurements. A design that released the level while BUSY was still high would raise the hold-violation count. Timeouts are forced twice: once by a converter that never answers and once by a BUSY that sticks high. A design that stopped too early, left a strobe or select driven, cleared err too soon, or still pulsed done would be caught there. A start issued during a sequence with the other mode selected would show up as extra convert pulses or a second done pulse in a design that accepted it.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

   typedef enum logic [2:0] {
      CS_IDLE,
      CS_SETUP,
      CS_STROBE,
      CS_WAIT_HI,
      CS_WAIT_LO
   } cs_state_e;

endpackage

// File: rtl/calseq_delay.sv
module calseq_delay #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/calseq_passes.sv
module calseq_passes #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] last_idx,
   output logic [W-1:0] idx,
   output logic         at_last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (clr)    idx <= '0;
      else if (inc)    idx <= idx + 1'b1;
   end

   assign at_last = (idx == last_idx);

endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
   import calseq_pkg::*;
#(
   parameter int CLK_KHZ     = 125000,
   parameter int SETUP_NS    = 100,
   parameter int STROBE_CYC  = 4,
   parameter int SEP_PASSES  = 2,
   parameter int COMB_PASSES = 3,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode_comb,
   input  logic             bipolar,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             busy_in,
   output logic             cal_stb,
   output logic             cnv_stb,
   output logic             sel_fs,
   output logic             sel_ofs,
   output logic             ofs_mid,
   output logic             active,
   output logic             done,
   output logic             err
);

   localparam int SETUP_CYC = (SETUP_NS * CLK_KHZ + 999_999) / 1_000_000;
   localparam int DLY_MAX   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int DLY_W     = $clog2(DLY_MAX + 1);
   localparam int PASS_MAX  = (SEP_PASSES > COMB_PASSES) ? SEP_PASSES : COMB_PASSES;
   localparam int PW        = $clog2(PASS_MAX + 1);
   localparam logic [DLY_W-1:0] SETUP_V  = DLY_W'(SETUP_CYC - 1);
   localparam logic [DLY_W-1:0] STROBE_V = DLY_W'(STROBE_CYC - 1);

   if (SETUP_CYC < 1 || STROBE_CYC < 1 || SEP_PASSES < 1 || COMB_PASSES < 1 ||
       COMB_PASSES > 3 || SYNC_STAGES < 0 || TMO_W < 1) begin : g_param_bad
      $error("calseq_ctrl: parameter out of range");
   end

   // BUSY synchroniser, depth chosen by parameter
   logic busy_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign busy_s = busy_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else begin
            sh_q[0] <= busy_in;
            for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
         end
      end
      assign busy_s = sh_q[SYNC_STAGES-1];
   end

   cs_state_e        st_q, st_d;
   logic             ph_q, ph_d;
   logic             mode_q, bip_q, done_q, err_q;
   logic             take, dly_load, tmo_load, pass_clr, pass_inc, done_d, err_set;
   logic [DLY_W-1:0] dly_val;
   logic             dly_exp, tmo_exp, at_last;
   logic [PW-1:0]    pass_idx, last_idx;

   assign last_idx = mode_q ? PW'(COMB_PASSES - 1) : PW'(SEP_PASSES - 1);

   calseq_delay #(.W(DLY_W)) u_setup_dly (
      .clk(clk), .rst_n(rst_n), .load(dly_load), .val(dly_val), .expired(dly_exp));

   calseq_delay #(.W(TMO_W)) u_busy_tmo (
      .clk(clk), .rst_n(rst_n), .load(tmo_load), .val(tmo_limit), .expired(tmo_exp));

   calseq_passes #(.W(PW)) u_passes (
      .clk(clk), .rst_n(rst_n), .clr(pass_clr), .inc(pass_inc),
      .last_idx(last_idx), .idx(pass_idx), .at_last(at_last));

   always_comb begin
      st_d     = st_q;
      ph_d     = ph_q;
      take     = 1'b0;
      dly_load = 1'b0;
      dly_val  = SETUP_V;
      tmo_load = 1'b0;
      pass_clr = 1'b0;
      pass_inc = 1'b0;
      done_d   = 1'b0;
      err_set  = 1'b0;
      unique case (st_q)
         CS_IDLE: if (start) begin
            take = 1'b1; st_d = CS_SETUP; ph_d = 1'b0; dly_load = 1'b1; pass_clr = 1'b1;
         end
         CS_SETUP: if (dly_exp) begin
            st_d = CS_STROBE; dly_load = 1'b1; dly_val = STROBE_V;
         end
         CS_STROBE: if (dly_exp) begin
            st_d = CS_WAIT_HI; tmo_load = 1'b1;
         end
         CS_WAIT_HI: begin
            if (busy_s) begin
               st_d = CS_WAIT_LO; tmo_load = 1'b1;
            end else if (tmo_exp) begin
               st_d = CS_IDLE; err_set = 1'b1;
            end
         end
         CS_WAIT_LO: begin
            if (!busy_s) begin
               if (!ph_q) begin
                  ph_d = 1'b1; st_d = CS_SETUP; dly_load = 1'b1;
               end else if (at_last) begin
                  st_d = CS_IDLE; done_d = 1'b1;
               end else begin
                  ph_d = 1'b0; st_d = CS_SETUP; dly_load = 1'b1; pass_inc = 1'b1;
               end
            end else if (tmo_exp) begin
               st_d = CS_IDLE; err_set = 1'b1;
            end
         end
         default: st_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         ph_q   <= 1'b0;
         mode_q <= 1'b0;
         bip_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         done_q <= done_d;
         if (take) begin
            mode_q <= mode_comb;
            bip_q  <= bipolar;
            err_q  <= 1'b0;
         end else if (err_set) begin
            err_q  <= 1'b1;
         end
      end
   end

   // full-scale phase: gain step of a separate pass, first step of a combined pass
   logic running, fs_phase;
   assign running  = (st_q != CS_IDLE);
   assign fs_phase = mode_q ? !ph_q : ph_q;

   assign sel_fs  = running && fs_phase;
   assign sel_ofs = running && !fs_phase;
   assign cal_stb = (st_q == CS_STROBE) && (!mode_q || !ph_q);
   assign cnv_stb = (st_q == CS_STROBE) && mode_q && ph_q;
   assign ofs_mid = bip_q;
   assign active  = running;
   assign done    = done_q;
   assign err     = err_q;

endmodule

// File: rtl/calseq_ctrl_chk.sv
module calseq_ctrl_chk #(
   parameter int PW          = 2,
   parameter int COMB_PASSES = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cal_stb,
   input logic          cnv_stb,
   input logic          sel_fs,
   input logic          sel_ofs,
   input logic          ofs_mid,
   input logic          active,
   input logic          done,
   input logic          err,
   input logic          mode_q,
   input logic [PW-1:0] pass_idx
);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(active) && !active);

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_stb && cnv_stb));

   // R6
   level_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_fs && sel_ofs));

   // R7
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !cal_stb && !cnv_stb && !sel_fs && !sel_ofs && !active && !done);

   // R4
   setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cal_stb) || $rose(cnv_stb)) |-> $stable(sel_fs) && $stable(sel_ofs) && (sel_fs || sel_ofs));

   // R11
   pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(ofs_mid));

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(mode_q));

   // R3
   comb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode_q) |-> (int'(pass_idx) < COMB_PASSES));

endmodule

bind calseq_ctrl calseq_ctrl_chk #(.PW(PW), .COMB_PASSES(COMB_PASSES)) u_calseq_chk (
   .clk(clk), .rst_n(rst_n), .cal_stb(cal_stb), .cnv_stb(cnv_stb),
   .sel_fs(sel_fs), .sel_ofs(sel_ofs), .ofs_mid(ofs_mid), .active(active),
   .done(done), .err(err), .mode_q(mode_q), .pass_idx(pass_idx));

// File: tb/calseq_ctrl_bench.sv
`timescale 1ns/1ps
module calseq_ctrl_bench;

   localparam int EXP_SETUP  = (100 * 125000 + 999_999) / 1_000_000;
   localparam int EXP_STROBE = 4;

   typedef struct packed {
      logic       comb;
      logic       bip;
      logic [3:0] bdly;
      logic [7:0] blen;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{1'b0, 1'b1, 4'd1, 8'd5},
      '{1'b1, 1'b0, 4'd2, 8'd30},
      '{1'b0, 1'b0, 4'd3, 8'd3},
      '{1'b1, 1'b1, 4'd1, 8'd100}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode_comb = 1'b0;
   logic        bipolar = 1'b0;
   logic [15:0] tmo_limit = 16'd1000;
   logic        busy = 1'b0;
   logic        cal_stb, cnv_stb, sel_fs, sel_ofs, ofs_mid, active, done, err;

   always #4 clk = ~clk;

   calseq_ctrl u_calseq_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_comb(mode_comb),
      .bipolar(bipolar), .tmo_limit(tmo_limit), .busy_in(busy),
      .cal_stb(cal_stb), .cnv_stb(cnv_stb), .sel_fs(sel_fs), .sel_ofs(sel_ofs),
      .ofs_mid(ofs_mid), .active(active), .done(done), .err(err));

   int checks = 0;
   int errors = 0;

   // converter model and monitors, all sampled at the falling edge
   logic model_en = 1'b1;
   logic mon_clr  = 1'b0;
   int   bdly = 1, blen = 5;
   int   dcnt = 0, hcnt = 0;
   logic pend = 1'b0;
   logic prev_stb = 1'b0, prev_fs = 1'b0, prev_ofs = 1'b0, prev_done = 1'b0;
   int   stab = 0, wid = 0, min_setup = 999, bad_width = 0, hold_viol = 0;
   int   n_cal = 0, n_cnv = 0, ev_n = 0, done_cnt = 0, done_dbl = 0;
   logic [1:0] ev [8];

   always @(negedge clk) begin
      logic stb_now;
      stb_now = cal_stb | cnv_stb;
      if (mon_clr) begin
         min_setup = 999; bad_width = 0; hold_viol = 0; n_cal = 0; n_cnv = 0;
         ev_n = 0; done_cnt = 0; done_dbl = 0; wid = 0; stab = 0;
      end else if (rst_n) begin
         if (sel_fs != prev_fs || sel_ofs != prev_ofs) begin
            stab = 0;
            if (busy) hold_viol++;
         end else begin
            stab++;
         end
         if (stb_now && !prev_stb) begin
            if (busy) hold_viol++;
            if (cal_stb) n_cal++;
            if (cnv_stb) n_cnv++;
            if (ev_n < 8) ev[ev_n] = {cnv_stb, sel_fs};
            ev_n++;
            if (stab < min_setup) min_setup = stab;
         end
         if (stb_now) wid++;
         else if (prev_stb) begin
            if (wid != EXP_STROBE) bad_width++;
            wid = 0;
         end
         if (done) begin
            done_cnt++;
            if (prev_done) done_dbl++;
         end
      end
      // converter response
      if (!rst_n) begin
         busy = 1'b0; pend = 1'b0;
      end else begin
         if (busy) begin
            if (hcnt == 0) busy = 1'b0;
            else hcnt--;
         end
         if (stb_now && !prev_stb && model_en) begin
            pend = 1'b1; dcnt = bdly;
         end else if (pend) begin
            if (dcnt <= 1) begin
               pend = 1'b0; busy = 1'b1; hcnt = blen;
            end else dcnt--;
         end
      end
      prev_stb  = stb_now;
      prev_fs   = sel_fs;
      prev_ofs  = sel_ofs;
      prev_done = done;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_ge(input string req, input string what, input int act, input int lim);
      checks++;
      if (act < lim) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic launch(input logic m, input logic b);
      tick(1);
      mon_clr = 1'b1; mode_comb = m; bipolar = b; start = 1'b1;
      tick(1);
      mon_clr = 1'b0; start = 1'b0;
   endtask

   task automatic wait_end(input int lim);
      for (int k = 0; k < lim; k++) begin
         tick(1);
         if (done_cnt > 0 || err) break;
      end
      tick(5);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1
      chk("R1", "outputs after reset",
          int'({cal_stb, cnv_stb, sel_fs, sel_ofs, ofs_mid, active, done, err}), 0);

      // table of routines and converter response shapes
      for (int i = 0; i < 4; i++) begin
         int steps;
         logic m;
         m = VECS[i].comb;
         bdly = int'(VECS[i].bdly);
         blen = int'(VECS[i].blen);
         model_en = 1'b1;
         launch(m, VECS[i].bip);
         bipolar = !VECS[i].bip;
         wait_end(20000);
         steps = m ? 6 : 4;
         chk(m ? "R3" : "R2", "cal pulses", n_cal, m ? 3 : 4);
         chk(m ? "R3" : "R2", "cnv pulses", n_cnv, m ? 3 : 0);
         chk(m ? "R3" : "R2", "step count", ev_n, steps);
         for (int k = 0; k < steps && k < 8; k++) begin
            logic [1:0] exp_ev;
            exp_ev = m ? {logic'(k % 2 == 1), logic'(k % 2 == 0)} : {1'b0, logic'(k % 2 == 1)};
            chk(m ? "R3" : "R2", "strobe/level order", int'(ev[k]), int'(exp_ev));
         end
         chk_ge("R4", "setup cycles", min_setup, EXP_SETUP);
         chk("R5", "strobe width errors", bad_width, 0);
         chk("R6", "level change while busy", hold_viol, 0);
         chk("R10", "done pulses", done_cnt, 1);
         chk("R10", "done wider than one cycle", done_dbl, 0);
         chk("R10", "idle after done", int'({active, sel_fs, sel_ofs, cal_stb, cnv_stb, err}), 0);
         chk("R11", "offset target held", int'(ofs_mid), int'(VECS[i].bip));
      end

      // R9: start with the other mode during a separate-mode run
      bdly = 1; blen = 8;
      launch(1'b0, 1'b0);
      for (int k = 0; k < 200 && n_cal == 0; k++) tick(1);
      mode_comb = 1'b1; start = 1'b1;
      tick(1);
      start = 1'b0;
      wait_end(20000);
      chk("R9", "cal pulses with start mid-run", n_cal, 4);
      chk("R9", "cnv pulses with start mid-run", n_cnv, 0);
      chk("R9", "done pulses with start mid-run", done_cnt, 1);

      // R7: converter never answers
      tmo_limit = 16'd40;
      model_en = 1'b0;
      launch(1'b0, 1'b1);
      for (int k = 0; k < 200 && n_cal == 0; k++) tick(1);
      tick(24);
      chk("R7", "no early abort", int'({err, active}), 1);
      wait_end(2000);
      chk("R7", "err after no-response timeout", int'(err), 1);
      chk("R7", "outputs idle after abort", int'({active, sel_fs, sel_ofs, cal_stb, cnv_stb}), 0);
      chk("R7", "no done on abort", done_cnt, 0);
      chk("R7", "single strobe before abort", n_cal, 1);
      tick(10);
      chk("R8", "err sticky", int'(err), 1);

      // R8: next accepted start clears err and runs normally
      tmo_limit = 16'd1000;
      model_en = 1'b1;
      bdly = 2; blen = 6;
      launch(1'b1, 1'b0);
      chk("R8", "err cleared by start", int'(err), 0);
      wait_end(20000);
      chk("R8", "run after clear completes", done_cnt, 1);
      chk("R3", "cnv pulses after clear", n_cnv, 3);

      // R7: BUSY stuck high past the limit
      tmo_limit = 16'd40;
      bdly = 1; blen = 200;
      launch(1'b1, 1'b1);
      wait_end(2000);
      chk("R7", "err after stuck busy", int'(err), 1);
      chk("R7", "idle after stuck busy", int'({active, sel_fs, sel_ofs, cal_stb, cnv_stb}), 0);
      chk("R7", "no done after stuck busy", done_cnt, 0);
      chk("R7", "no cnv after stuck busy", n_cnv, 0);
      tick(250);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule